// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block is the receive half of a synchronous serial port running as a clock slave. A remote master drives the shift clock and the data line. The block never drives the clock. It passes both lines through a synchroniser into the core clock domain and detects rising edges of the external clock. On each rising edge it shifts in one data bit, least-significant bit first. When a full word of eight bits, or nine bits in extended mode, has arrived, the word moves into a holding register. A receive-complete flag is then set, and an interrupt is raised if the interrupt enable is set.

Reception runs only while the port enable and the continuous-receive enable are both high. The single-receive control exists for compatibility with master mode, and in this mode it does nothing. In nine-bit mode the extra bit appears in the status word beside the overrun error bit. Software reads the status first and then the data. A read strobe on the data register clears the flag. An overrun stops reception until software drops the continuous-receive enable. The interrupt output is a plain combinational level taken from the flag, so it can wake a sleeping system.

Top module: `ssr_rx`

## Requirements
- R1: After the eighth rising edge of `ext_sclk` in 8-bit mode, `rx_data` holds the received bits with the first bit received in bit 0, and `rx_done` is 1.
- R2: When `nine_bit_sel` is 1, the first eight bits received go to `rx_data[7:0]` and the ninth goes to `rx_status[0]`. In 8-bit mode `rx_status[0]` reads 0.
- R3: `single_rx_en` has no effect. With `cont_rx_en` low nothing is received, whatever its value. With `cont_rx_en` high, words arrive correctly whatever its value.
- R4: Bits are shifted only while `port_en` and `cont_rx_en` are both 1. Dropping `cont_rx_en` throws away a partial word.
- R5: `rx_irq` is 1 exactly when `rx_done` is 1 and `irq_en` is 1.
- R6: A one-cycle pulse on `rd_data` clears `rx_done` by the next cycle.
- R7: If a word completes while `rx_done` is still 1, `rx_status[1]` (overrun) is set and `rx_data` keeps the old word. Shifting then stops. Overrun stays set until `cont_rx_en` is driven to 0.
- R8: Driving `port_en` to 0 clears `rx_done`, `rx_status`, `rx_data` and any partial word.
- R9: A word completes only at the last rising edge of its length. After seven rising edges in 8-bit mode, `rx_done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Port enable; low clears the receive state |
| cont_rx_en | input | 1 | Continuous-receive enable; low clears overrun |
| single_rx_en | input | 1 | Single-receive enable, ignored in slave mode |
| nine_bit_sel | input | 1 | 1 selects 9-bit words |
| irq_en | input | 1 | Receive interrupt enable |
| ext_sclk | input | 1 | Externally supplied shift clock |
| ext_data | input | 1 | Serial data, sampled on rising shift-clock edges |
| rd_data | input | 1 | One-cycle strobe: data register is being read |
| rx_data | output | 8 | Received data register |
| rx_status | output | 2 | Bit 0 ninth bit, bit 1 overrun error |
| rx_done | output | 1 | Receive-complete flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume the following about the inputs:
- Each level of `ext_sclk` lasts at least two core clock cycles.
- `ext_data` is steady around every rising edge of `ext_sclk`.
- `rd_data` is a short pulse.

The assertions also assume that `nine_bit_sel` does not change in the middle of a word. The stimulus keeps within these limits. It holds each shift-clock phase for four core cycles and sets the data bit while the clock is low. It changes mode and enables only between words, and it pulses `rd_data` for exactly one cycle.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    localparam int STAT_W = 2;

    typedef struct packed {
        logic overrun;
        logic ninth;
    } rx_stat_t;

    function automatic logic rx_live(input logic pen, input logic cen, input logic ovr);
        return pen & cen & ~ovr;
    endfunction
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    input  logic data_in,
    output logic sclk_rise,
    output logic data_s
);
    logic [STAGES-1:0] ck_pipe;
    logic [STAGES-1:0] dt_pipe;
    logic              ck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_pipe <= '0;
            dt_pipe <= '0;
            ck_prev <= 1'b0;
        end else begin
            ck_pipe <= {ck_pipe[STAGES-2:0], sclk_in};
            dt_pipe <= {dt_pipe[STAGES-2:0], data_in};
            ck_prev <= ck_pipe[STAGES-1];
        end
    end

    assign sclk_rise = ck_pipe[STAGES-1] & ~ck_prev;
    assign data_s    = dt_pipe[STAGES-1];
endmodule

// File: rtl/ssr_shift.sv
module ssr_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              live,
    input  logic              port_en,
    input  logic              nine,
    input  logic              rise,
    input  logic              din,
    output logic              done_q,
    output logic [DATA_W-1:0] word_q,
    output logic              ninth_q
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [DATA_W:0]   sr;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last_idx;
    logic [DATA_W:0]   nxt;

    assign last_idx = nine ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
    assign nxt      = {din, sr[DATA_W:1]};

    always_ff @(posedge clk) begin
        if (rst || !port_en) begin
            sr      <= '0;
            cnt     <= '0;
            done_q  <= 1'b0;
            word_q  <= '0;
            ninth_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!live) begin
                cnt <= '0;
            end else if (rise) begin
                sr <= nxt;
                if (cnt == last_idx) begin
                    cnt    <= '0;
                    done_q <= 1'b1;
                    if (nine) begin
                        word_q  <= nxt[DATA_W-1:0];
                        ninth_q <= nxt[DATA_W];
                    end else begin
                        word_q  <= nxt[DATA_W:1];
                        ninth_q <= 1'b0;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R9
    word_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(rise));
endmodule

// File: rtl/ssr_hold.sv
module ssr_hold
    import ssr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic              cont_en,
    input  logic              rd,
    input  logic              word_done,
    input  logic [DATA_W-1:0] word,
    input  logic              word_ninth,
    output logic [DATA_W-1:0] data_q,
    output rx_stat_t          stat_q,
    output logic              flag_q
);
    logic full_now;
    assign full_now = flag_q & ~rd;

    always_ff @(posedge clk) begin
        if (rst || !port_en) begin
            data_q <= '0;
            stat_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (!cont_en) stat_q.overrun <= 1'b0;
            if (word_done) begin
                if (full_now) begin
                    stat_q.overrun <= 1'b1;
                end else begin
                    data_q       <= word;
                    stat_q.ninth <= word_ninth;
                    flag_q       <= 1'b1;
                end
            end else if (rd) begin
                flag_q <= 1'b0;
            end
        end
    end

    // R1
    flag_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(word_done));
    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        rd && !word_done |=> !flag_q);
    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        stat_q.overrun && cont_en && port_en |=> stat_q.overrun);
    // R7
    overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        word_done && flag_q && !rd && port_en |=> $stable(data_q));
endmodule

// File: rtl/ssr_rx.sv
module ssr_rx
    import ssr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic              cont_rx_en,
    input  logic              single_rx_en,
    input  logic              nine_bit_sel,
    input  logic              irq_en,
    input  logic              ext_sclk,
    input  logic              ext_data,
    input  logic              rd_data,
    output logic [DATA_W-1:0] rx_data,
    output logic [STAT_W-1:0] rx_status,
    output logic              rx_done,
    output logic              rx_irq
);
    logic              rise;
    logic              din;
    logic              live;
    logic              word_done;
    logic [DATA_W-1:0] word;
    logic              word_ninth;
    rx_stat_t          stat;
    logic              unused_single;

    assign unused_single = single_rx_en;
    assign live          = rx_live(port_en, cont_rx_en, stat.overrun);

    ssr_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .sclk_in(ext_sclk), .data_in(ext_data),
        .sclk_rise(rise), .data_s(din)
    );

    ssr_shift #(.DATA_W(DATA_W)) i_shift (
        .clk(clk), .rst(rst), .live(live), .port_en(port_en),
        .nine(nine_bit_sel), .rise(rise), .din(din),
        .done_q(word_done), .word_q(word), .ninth_q(word_ninth)
    );

    ssr_hold #(.DATA_W(DATA_W)) i_hold (
        .clk(clk), .rst(rst), .port_en(port_en), .cont_en(cont_rx_en),
        .rd(rd_data), .word_done(word_done), .word(word),
        .word_ninth(word_ninth), .data_q(rx_data), .stat_q(stat),
        .flag_q(rx_done)
    );

    assign rx_status = stat;
    assign rx_irq    = rx_done & irq_en;

    // R4
    enabled_word_chk: assert property (@(posedge clk) disable iff (rst)
        word_done |-> $past(port_en && cont_rx_en));
    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> irq_en);
endmodule

// File: tb/test_ssr_rx.sv
module test_ssr_rx;
    localparam int CLK_PERIOD = 10;
    localparam int PHASE      = 4;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic port_en = 1'b0, cont_rx_en = 1'b0, single_rx_en = 1'b0;
    logic nine_bit_sel = 1'b0, irq_en = 1'b0;
    logic ext_sclk = 1'b0, ext_data = 1'b0, rd_data = 1'b0;
    logic [7:0] rx_data;
    logic [1:0] rx_status;
    logic rx_done, rx_irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssr_rx i_ssr_rx (
        .clk(clk), .rst(rst), .port_en(port_en), .cont_rx_en(cont_rx_en),
        .single_rx_en(single_rx_en), .nine_bit_sel(nine_bit_sel),
        .irq_en(irq_en), .ext_sclk(ext_sclk), .ext_data(ext_data),
        .rd_data(rd_data), .rx_data(rx_data), .rx_status(rx_status),
        .rx_done(rx_done), .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [8:0] v, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            ext_data = v[i];
            ext_sclk = 1'b0;
            wait_n(PHASE);
            ext_sclk = 1'b1;
            wait_n(PHASE);
            ext_sclk = 1'b0;
        end
        wait_n(PHASE);
    endtask

    task automatic do_read();
        rd_data = 1'b1;
        wait_n(1);
        rd_data = 1'b0;
        wait_n(1);
    endtask

    initial begin
        wait_n(WATCHDOG);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        // R8: reset state
        chk("R8 reset done", int'(rx_done), 0);
        chk("R8 reset status", int'(rx_status), 0);
        chk("R5 reset irq", int'(rx_irq), 0);

        port_en = 1'b1;
        cont_rx_en = 1'b1;
        wait_n(2);

        // R1 / R5 / R6 exhaustive 8-bit sweep
        for (int v = 0; v < 256; v++) begin
            irq_en = v[0];
            single_rx_en = v[1];
            send_bits(9'(v), 8);
            chk("R1 done", int'(rx_done), 1);
            chk("R1 data", int'(rx_data), v);
            chk("R2 ninth zero in 8-bit", int'(rx_status[0]), 0);
            chk("R5 irq", int'(rx_irq), v & 1);
            do_read();
            chk("R6 read clears", int'(rx_done), 0);
            chk("R5 irq after read", int'(rx_irq), 0);
        end

        // R2 exhaustive 9-bit sweep
        nine_bit_sel = 1'b1;
        irq_en = 1'b1;
        for (int v = 0; v < 512; v++) begin
            send_bits(9'(v), 9);
            chk("R2 data", int'(rx_data), v & 8'hFF);
            chk("R2 ninth", int'(rx_status[0]), (v >> 8) & 1);
            chk("R2 done", int'(rx_done), 1);
            do_read();
        end
        nine_bit_sel = 1'b0;

        // R9 partial word, then R4 discard on cont toggle
        send_bits(9'h0FF, 7);
        chk("R9 seven edges", int'(rx_done), 0);
        cont_rx_en = 1'b0;
        wait_n(2);
        cont_rx_en = 1'b1;
        wait_n(2);
        send_bits(9'h0A5, 8);
        chk("R4 partial discarded", int'(rx_data), 8'hA5);
        do_read();

        // R3 single-receive alone does nothing
        cont_rx_en = 1'b0;
        single_rx_en = 1'b1;
        wait_n(2);
        send_bits(9'h03C, 8);
        chk("R3 single ignored done", int'(rx_done), 0);
        chk("R3 single ignored data", int'(rx_data), 8'hA5);
        cont_rx_en = 1'b1;
        single_rx_en = 1'b0;
        wait_n(2);

        // R4 port disabled
        port_en = 1'b0;
        wait_n(2);
        send_bits(9'h055, 8);
        chk("R4 port off done", int'(rx_done), 0);
        port_en = 1'b1;
        wait_n(2);

        // R7 overrun
        send_bits(9'h011, 8);
        send_bits(9'h022, 8);
        chk("R7 overrun set", int'(rx_status[1]), 1);
        chk("R7 data kept", int'(rx_data), 8'h11);
        chk("R7 flag kept", int'(rx_done), 1);
        do_read();
        chk("R6 read during overrun", int'(rx_done), 0);
        send_bits(9'h033, 8);
        chk("R7 shifting stopped", int'(rx_done), 0);
        chk("R7 still overrun", int'(rx_status[1]), 1);
        chk("R7 data unchanged", int'(rx_data), 8'h11);
        cont_rx_en = 1'b0;
        wait_n(2);
        chk("R7 cleared by cont off", int'(rx_status[1]), 0);
        cont_rx_en = 1'b1;
        wait_n(2);
        send_bits(9'h044, 8);
        chk("R7 resumed data", int'(rx_data), 8'h44);
        chk("R7 resumed no overrun", int'(rx_status[1]), 0);

        // R8 port disable clears
        send_bits(9'h066, 8);
        chk("R8 overrun before", int'(rx_status[1]), 1);
        port_en = 1'b0;
        wait_n(2);
        chk("R8 done cleared", int'(rx_done), 0);
        chk("R8 status cleared", int'(rx_status), 0);
        chk("R8 data cleared", int'(rx_data), 0);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule